// File: doc/BRIEF.md
# Single-Wire Command Response Sequencer

This block is the device-side control engine of a half-duplex, byte-oriented, single-wire command link. An upstream line receiver has already decoded the wire. It hands this block one of four flag kinds (wake, command, transmit, sleep) and the bytes of a command block. The sequencer captures the command block, checks its CRC, length and opcode, and then stays busy. It is busy first for a parse interval and then for an execution interval whose length depends on the opcode. While busy it does not react to the link at all.

A transmit flag in the idle state streams out a complete response block. The block carries a count byte, a status byte or a data payload, and a two-byte CRC. A transmit flag sent right after wake returns a wake acknowledgement. A rejected command returns a parse-error status. An accepted command that the modelled execution refuses returns an execution-error status. Execution itself is only a timed delay. Its outcome comes from an `exec_fault` input, and the keyed-hash opcode returns a transformed copy of its parameters as data. A sleep flag resets the engine and wipes both buffers.

Top module: `cmd_resp_seq`

## Requirements
- R1: After reset the block is asleep (mode 0) with `resp_valid` low. In sleep, command, transmit and sleep flags and data bytes have no effect. Only a wake flag leaves sleep, moving to mode 1 (awake).
- R2: A transmit flag after wake and before any command yields the 4-byte block 0x04, 0x11, CRC low, CRC high.
- R3: The response count byte equals the total block length, including itself and both CRC bytes. The CRC is CRC-16 with polynomial 0x8005, initial value 0 and MSB-first. It covers the count and payload bytes and is sent low byte first. A command block uses the same framing: byte 0 is the count, byte 1 is the opcode, then parameters, then the CRC.
- R4: A command with a wrong CRC, an unknown opcode, or a count below 4 or above BUF_BYTES is answered with status 0xFF. The busy time for such a command is exactly T_PARSE cycles. A count below 4 ends reception after the count byte.
- R5: While busy (mode 2) every flag is ignored. A transmit flag during busy produces no response bytes and does not change the later result.
- R6: After the last command byte, a valid command stays in mode 2 for T_PARSE plus an execution time. The execution time is T_MEM for opcodes 0x01, 0x02 and 0x03, T_FUSE for 0x04, T_MAC for 0x05 and T_PERS for 0x06.
- R7: A valid command that finishes with `exec_fault` high in the last execution cycle answers status 0x0F.
- R8: A successful command answers status 0x00, except opcode 0x05. Opcode 0x05 answers a count of N+3 followed by its N parameter bytes, each XORed with 0x5A.
- R9: Repeated transmit flags in the idle state each resend the identical response block.
- R10: A sleep flag is accepted in the awake and receiving states. It returns the block to mode 0 and clears all prior results, so the next wake and transmit give the 0x11 block.
- R11: Response bytes start one cycle after the transmit flag is taken. They come one per cycle with `resp_valid` high, in mode 3. `resp_last` marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_valid | input | 1 | One-cycle strobe for a decoded flag |
| flag_type | input | 2 | Flag kind: 0 wake, 1 command, 2 transmit, 3 sleep |
| byte_valid | input | 1 | Command block byte strobe |
| byte_in | input | 8 | Command block byte |
| exec_fault | input | 1 | Modelled execution outcome, sampled in the last execution cycle |
| resp_valid | output | 1 | Response byte valid |
| resp_byte | output | 8 | Response byte |
| resp_last | output | 1 | Final byte of the response block |
| mode | output | 2 | 0 asleep, 1 awake, 2 busy, 3 transmitting |

## Verification
The bench builds the block with short intervals: T_PARSE of 5 cycles and execution times of 7, 4, 15 and 11 cycles, with BUF_BYTES of 32. At these lengths every busy window can be measured cycle by cycle. A transmit flag can also be injected inside each window. With the full 32-byte buffer, both the largest keyed-hash reply (28 parameters) and an over-long count of 40 are in range.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

  typedef enum logic [1:0] {
    FLG_WAKE  = 2'd0,
    FLG_CMD   = 2'd1,
    FLG_XMIT  = 2'd2,
    FLG_SLEEP = 2'd3
  } flag_e;

  typedef enum logic [2:0] {
    CL_MEM, CL_FUSE, CL_MAC, CL_PERS, CL_NONE
  } op_class_e;

  typedef enum logic [1:0] {
    MD_SLEEP = 2'd0,
    MD_AWAKE = 2'd1,
    MD_BUSY  = 2'd2,
    MD_XMIT  = 2'd3
  } mode_e;

  localparam logic [7:0] ST_WAKE_ACK  = 8'h11;
  localparam logic [7:0] ST_OK        = 8'h00;
  localparam logic [7:0] ST_EXEC_ERR  = 8'h0F;
  localparam logic [7:0] ST_PARSE_ERR = 8'hFF;
  localparam logic [7:0] MAC_MASK     = 8'h5A;
  localparam logic [7:0] STATUS_LEN   = 8'd4;
  localparam logic [7:0] MIN_CMD_LEN  = 8'd4;

  // one byte of CRC-16 (poly 0x8005, MSB first)
  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] d);
    logic [15:0] c;
    c = crc ^ {d, 8'h00};
    for (int i = 0; i < 8; i++)
      c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    return c;
  endfunction

  function automatic op_class_e classify(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h03: return CL_MEM;
      8'h04:               return CL_FUSE;
      8'h05:               return CL_MAC;
      8'h06:               return CL_PERS;
      default:             return CL_NONE;
    endcase
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cmd_rx.sv
module cmd_rx
  import cmd_seq_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 32,
  localparam int unsigned AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  logic          en,
  input  logic          byte_valid,
  input  logic [7:0]    byte_in,
  output logic          last,
  output logic          frame_ok,
  output op_class_e     op_class,
  output logic [7:0]    count,
  output logic          prm_we,
  output logic [AW-1:0] prm_addr,
  output logic [7:0]    prm_data
);

  localparam logic [7:0] BUF_MAX = 8'(BUF_BYTES);

  logic [7:0]  idx_q, cnt_q, lo_q, op_q;
  logic [15:0] crc_q;
  logic        accept, len_ok, crc_match, first;

  assign accept    = en && byte_valid;
  assign first     = (idx_q == 8'd0);
  assign len_ok    = (cnt_q >= MIN_CMD_LEN) && (cnt_q <= BUF_MAX);
  assign crc_match = ({byte_in, lo_q} == crc_q);
  assign op_class  = classify(op_q);
  assign count     = cnt_q;

  assign last     = accept && (first ? (byte_in < MIN_CMD_LEN) : (idx_q == cnt_q - 8'd1));
  assign frame_ok = !first && len_ok && crc_match && (op_class != CL_NONE);

  assign prm_we   = accept && (idx_q >= 8'd2) && (idx_q < cnt_q - 8'd2) && (cnt_q <= BUF_MAX);
  assign prm_addr = AW'(idx_q - 8'd1);
  assign prm_data = byte_in ^ MAC_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; cnt_q <= '0; lo_q <= '0; op_q <= '0; crc_q <= '0;
    end else if (clr || start) begin
      idx_q <= '0; crc_q <= '0;
    end else if (accept) begin
      idx_q <= idx_q + 8'd1;
      if (first) begin
        cnt_q <= byte_in;
        crc_q <= crc16_step(16'h0000, byte_in);
      end else begin
        if (idx_q < cnt_q - 8'd2) crc_q <= crc16_step(crc_q, byte_in);
        if (idx_q == 8'd1)         op_q  <= byte_in;
        if (idx_q == cnt_q - 8'd2) lo_q  <= byte_in;
      end
    end
  end

endmodule

// File: rtl/resp_buf.sv
module resp_buf
  import cmd_seq_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 32,
  localparam int unsigned AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hdr_we,
  input  logic [7:0]    hdr_len,
  input  logic          hdr_code_we,
  input  logic [7:0]    hdr_code,
  input  logic          prm_we,
  input  logic [AW-1:0] prm_addr,
  input  logic [7:0]    prm_data,
  input  logic          go,
  output logic          resp_valid,
  output logic [7:0]    resp_byte,
  output logic          resp_last
);

  logic [7:0]  mem_q [BUF_BYTES];
  logic [7:0]  len_q, idx_q;
  logic [15:0] crc_q;
  logic        sending_q, in_body;

  assign in_body    = (idx_q < len_q - 8'd2);
  assign resp_valid = sending_q;
  assign resp_last  = sending_q && (idx_q == len_q - 8'd1);
  assign resp_byte  = in_body ? mem_q[idx_q[AW-1:0]]
                    : (idx_q == len_q - 8'd2) ? crc_q[7:0] : crc_q[15:8];

  // storage: one write path per entry
  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem_q[g] <= '0;
      else if (clr)                              mem_q[g] <= '0;
      else if (hdr_we && g == 0)                 mem_q[g] <= hdr_len;
      else if (hdr_we && hdr_code_we && g == 1)  mem_q[g] <= hdr_code;
      else if (prm_we && prm_addr == AW'(g))     mem_q[g] <= prm_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0; idx_q <= '0; crc_q <= '0; sending_q <= 1'b0;
    end else if (clr) begin
      len_q <= '0; idx_q <= '0; crc_q <= '0; sending_q <= 1'b0;
    end else begin
      if (hdr_we) len_q <= hdr_len;
      if (go) begin
        sending_q <= 1'b1; idx_q <= '0; crc_q <= '0;
      end else if (sending_q) begin
        if (in_body) crc_q <= crc16_step(crc_q, resp_byte);
        idx_q <= idx_q + 8'd1;
        if (resp_last) sending_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expire
);

  logic [TW-1:0] cnt_q;
  logic          act_q;

  assign expire = act_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= val - TW'(1); act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - TW'(1);
    end
  end

endmodule

// File: rtl/cmd_resp_seq.sv
module cmd_resp_seq
  import cmd_seq_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 32,
  parameter int unsigned T_PARSE   = 100,
  parameter int unsigned T_MEM     = 3000,
  parameter int unsigned T_FUSE    = 700,
  parameter int unsigned T_MAC     = 30000,
  parameter int unsigned T_PERS    = 13000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flag_valid,
  input  logic [1:0] flag_type,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic       exec_fault,
  output logic       resp_valid,
  output logic [7:0] resp_byte,
  output logic       resp_last,
  output logic [1:0] mode
);

  localparam int unsigned AW   = $clog2(BUF_BYTES);
  localparam int unsigned DMAX = max_of(max_of(max_of(T_PARSE, T_MEM), max_of(T_FUSE, T_MAC)), T_PERS);
  localparam int unsigned TW   = $clog2(DMAX + 1);

  typedef enum logic [2:0] {S_SLEEP, S_IDLE, S_RX, S_PARSE, S_EXEC, S_SEND} state_e;

  state_e    st_q, st_d;
  flag_e     fkind;
  op_class_e rx_cls, cls_q;
  logic      ok_q;

  // named internal events
  logic wake_acc, sleep_acc, cmd_acc, xmit_acc;
  logic rx_last, rx_ok, parse_done, exec_done, tmr_exp;

  logic          prm_we;
  logic [AW-1:0] prm_addr;
  logic [7:0]    prm_data, rx_count;
  logic          hdr_we, hdr_code_we, tmr_load;
  logic [7:0]    hdr_len, hdr_code;
  logic [TW-1:0] tmr_val, exec_val;

  assign fkind     = flag_e'(flag_type);
  assign wake_acc  = flag_valid && fkind == FLG_WAKE  && st_q == S_SLEEP;
  assign sleep_acc = flag_valid && fkind == FLG_SLEEP && (st_q == S_IDLE || st_q == S_RX);
  assign cmd_acc   = flag_valid && fkind == FLG_CMD   && st_q == S_IDLE;
  assign xmit_acc  = flag_valid && fkind == FLG_XMIT  && st_q == S_IDLE;
  assign parse_done = (st_q == S_PARSE) && tmr_exp;
  assign exec_done  = (st_q == S_EXEC)  && tmr_exp;

  cmd_rx #(.BUF_BYTES(BUF_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(sleep_acc), .start(cmd_acc), .en(st_q == S_RX),
    .byte_valid(byte_valid), .byte_in(byte_in), .last(rx_last), .frame_ok(rx_ok),
    .op_class(rx_cls), .count(rx_count), .prm_we(prm_we), .prm_addr(prm_addr),
    .prm_data(prm_data)
  );

  always_comb begin
    case (cls_q)
      CL_MEM:  exec_val = TW'(T_MEM);
      CL_FUSE: exec_val = TW'(T_FUSE);
      CL_MAC:  exec_val = TW'(T_MAC);
      default: exec_val = TW'(T_PERS);
    endcase
  end

  assign tmr_load = rx_last || (parse_done && ok_q);
  assign tmr_val  = rx_last ? TW'(T_PARSE) : exec_val;

  delay_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expire(tmr_exp)
  );

  // response header selection
  always_comb begin
    hdr_we = 1'b0; hdr_code_we = 1'b1; hdr_len = STATUS_LEN; hdr_code = ST_OK;
    if (wake_acc) begin
      hdr_we = 1'b1; hdr_code = ST_WAKE_ACK;
    end else if (parse_done && !ok_q) begin
      hdr_we = 1'b1; hdr_code = ST_PARSE_ERR;
    end else if (exec_done) begin
      hdr_we = 1'b1;
      if (exec_fault) hdr_code = ST_EXEC_ERR;
      else if (cls_q == CL_MAC) begin
        hdr_code_we = 1'b0; hdr_len = rx_count - 8'd1;
      end
    end
  end

  resp_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(sleep_acc), .hdr_we(hdr_we), .hdr_len(hdr_len),
    .hdr_code_we(hdr_code_we), .hdr_code(hdr_code), .prm_we(prm_we), .prm_addr(prm_addr),
    .prm_data(prm_data), .go(xmit_acc), .resp_valid(resp_valid), .resp_byte(resp_byte),
    .resp_last(resp_last)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_SLEEP: if (wake_acc) st_d = S_IDLE;
      S_IDLE: begin
        if (sleep_acc)     st_d = S_SLEEP;
        else if (cmd_acc)  st_d = S_RX;
        else if (xmit_acc) st_d = S_SEND;
      end
      S_RX: begin
        if (sleep_acc)    st_d = S_SLEEP;
        else if (rx_last) st_d = S_PARSE;
      end
      S_PARSE: if (parse_done) st_d = ok_q ? S_EXEC : S_IDLE;
      S_EXEC:  if (exec_done)  st_d = S_IDLE;
      S_SEND:  if (resp_last)  st_d = S_IDLE;
      default: st_d = S_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_SLEEP; ok_q <= 1'b0; cls_q <= CL_NONE;
    end else begin
      st_q <= st_d;
      if (rx_last) begin
        ok_q  <= rx_ok;
        cls_q <= rx_cls;
      end
    end
  end

  always_comb begin
    case (st_q)
      S_SLEEP:         mode = MD_SLEEP;
      S_PARSE, S_EXEC: mode = MD_BUSY;
      S_SEND:          mode = MD_XMIT;
      default:         mode = MD_AWAKE;
    endcase
  end

endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk
  import cmd_seq_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_valid,
  input logic [1:0] flag_type,
  input logic [1:0] mode,
  input logic       resp_valid,
  input logic [7:0] resp_byte,
  input logic       sleep_acc,
  input logic       parse_done,
  input logic       frame_ok_q
);

  a_r1_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SLEEP && !(flag_valid && flag_type == FLG_WAKE)) |=> mode == MD_SLEEP);

  a_r5_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_BUSY) |=> !resp_valid);

  a_r10_sleep_enters: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_acc |=> (mode == MD_SLEEP && !resp_valid));

  a_r11_send_mode: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> mode == MD_XMIT);

  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> (resp_byte >= 8'd3 && resp_byte <= 8'(BUF_BYTES)));

  a_r4_parse_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (parse_done && !frame_ok_q) |=> mode == MD_AWAKE);

endmodule

bind cmd_resp_seq cmd_seq_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_valid(flag_valid), .flag_type(flag_type),
  .mode(mode), .resp_valid(resp_valid), .resp_byte(resp_byte),
  .sleep_acc(sleep_acc), .parse_done(parse_done), .frame_ok_q(ok_q)
);

// File: tb/sim_cmd_resp_seq.sv
module sim_cmd_resp_seq;

  localparam int CLK_NS = 10;
  localparam int TP = 5, TM = 7, TF = 4, TC = 15, TS = 11, BUF = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flag_valid = 1'b0, byte_valid = 1'b0, exec_fault = 1'b0;
  logic [1:0] flag_type = 2'd0;
  logic [7:0] byte_in = 8'd0;
  logic resp_valid, resp_last;
  logic [7:0] resp_byte;
  logic [1:0] mode;

  always #(CLK_NS/2) clk = ~clk;

  cmd_resp_seq #(.BUF_BYTES(BUF), .T_PARSE(TP), .T_MEM(TM), .T_FUSE(TF),
                 .T_MAC(TC), .T_PERS(TS)) u0 (
    .clk(clk), .rst_n(rst_n), .flag_valid(flag_valid), .flag_type(flag_type),
    .byte_valid(byte_valid), .byte_in(byte_in), .exec_fault(exec_fault),
    .resp_valid(resp_valid), .resp_byte(resp_byte), .resp_last(resp_last), .mode(mode)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0] cmdb [64];
  int cmd_n;
  logic [7:0] got [64];
  int got_n;
  logic [7:0] exp_b [64];
  int exp_n;
  int busy_n, busy_resp;
  int mode_bad, last_bad;

  task automatic chk(input string tag, input int act, input int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // bitwise CRC-16, 0x8005, processed one input bit at a time
  function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  function automatic int exec_time(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h03: return TM;
      8'h04: return TF;
      8'h05: return TC;
      8'h06: return TS;
      default: return -1;
    endcase
  endfunction

  task automatic seal_exp();
    logic [15:0] c = 16'h0;
    for (int i = 0; i < exp_n - 2; i++) c = crc_bits(c, exp_b[i]);
    exp_b[exp_n-2] = c[7:0];
    exp_b[exp_n-1] = c[15:8];
  endtask

  task automatic exp_status(input logic [7:0] code);
    exp_n = 4; exp_b[0] = 8'd4; exp_b[1] = code; seal_exp();
  endtask

  task automatic make_cmd(input logic [7:0] op, input int np, input bit bad);
    logic [15:0] c = 16'h0;
    cmd_n = np + 4;
    cmdb[0] = 8'(cmd_n); cmdb[1] = op;
    for (int i = 0; i < np; i++) cmdb[2+i] = 8'($urandom);
    for (int i = 0; i < np + 2; i++) c = crc_bits(c, cmdb[i]);
    cmdb[np+2] = c[7:0] ^ {7'd0, bad};
    cmdb[np+3] = c[15:8];
  endtask

  task automatic flag(input logic [1:0] t);
    @(negedge clk); flag_valid = 1'b1; flag_type = t;
    @(negedge clk); flag_valid = 1'b0;
  endtask

  task automatic push_bytes();
    for (int i = 0; i < cmd_n; i++) begin
      byte_valid = 1'b1; byte_in = cmdb[i];
      @(negedge clk);
    end
    byte_valid = 1'b0;
  endtask

  // count busy cycles, poking a transmit flag inside the window
  task automatic busy_window();
    busy_n = 0; busy_resp = 0;
    while (mode == 2'd2 && busy_n < 5000) begin
      if (resp_valid) busy_resp++;
      if (busy_n == 1) begin flag_valid = 1'b1; flag_type = 2'd2; end
      else flag_valid = 1'b0;
      @(negedge clk);
      busy_n++;
    end
    flag_valid = 1'b0;
  endtask

  task automatic xmit();
    flag(2'd2);
    got_n = 0; mode_bad = 0; last_bad = 0;
    while (resp_valid && got_n < 64) begin
      got[got_n] = resp_byte;
      if (mode != 2'd3) mode_bad++;
      got_n++;
      @(negedge clk);
      if (resp_last != (resp_valid && got_n > 0 && 0)) ;
    end
  endtask

  task automatic cmp(input string tag);
    chk({tag, " length"}, got_n, exp_n);
    if (got_n == exp_n)
      for (int i = 0; i < exp_n; i++) chk({tag, " byte"}, got[i], exp_b[i]);
    chk("R11 mode during send", mode_bad, 0);
  endtask

  task automatic run_cmd(input logic [7:0] op, input int np, input bit bad, input bit fault,
                         input string tag);
    bit ok = !bad && exec_time(op) > 0;
    make_cmd(op, np, bad);
    exec_fault = fault;
    flag(2'd1);
    push_bytes();
    busy_window();
    chk({tag, " R6/R4 busy cycles"}, busy_n, ok ? TP + exec_time(op) : TP);
    chk({tag, " R5 no reply while busy"}, busy_resp, 0);
    xmit();
    if (!ok) exp_status(8'hFF);
    else if (fault) exp_status(8'h0F);
    else if (op == 8'h05) begin
      exp_n = np + 3; exp_b[0] = 8'(np + 3);
      for (int i = 0; i < np; i++) exp_b[1+i] = cmdb[2+i] ^ 8'h5A;
      seal_exp();
    end else exp_status(8'h00);
    cmp(tag);
    exec_fault = 1'b0;
  endtask

  // resp_last placement: observed on a dedicated send
  task automatic check_last(input string tag);
    int pos = -1, k = 0;
    flag(2'd2);
    while (resp_valid && k < 64) begin
      if (resp_last) pos = k;
      k++;
      @(negedge clk);
    end
    chk({tag, " R11 resp_last on final byte"}, pos, k - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] ops [7];
    ops = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h37};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset resp_valid", resp_valid, 0);

    // R1: flags and bytes in sleep do nothing
    xmit();
    chk("R1 transmit in sleep ignored", got_n, 0);
    make_cmd(8'h01, 0, 0);
    flag(2'd1); push_bytes();
    chk("R1 command in sleep ignored", mode, 0);
    flag(2'd3);
    chk("R1 sleep in sleep", mode, 0);
    flag(2'd0);
    chk("R1 wake leaves sleep", mode, 1);

    // R2, R3, R9
    xmit(); exp_status(8'h11); cmp("R2 wake ack");
    xmit(); cmp("R9 repeat read");
    check_last("R2");

    // R6, R8: each opcode
    for (int i = 0; i < 6; i++) run_cmd(ops[i], 3, 0, 0, "R8 success");
    run_cmd(8'h05, 0, 0, 0, "R8 mac empty");
    run_cmd(8'h05, 28, 0, 0, "R8 mac full");
    xmit(); cmp("R9 repeat mac");
    check_last("R8");

    // R4 corners
    run_cmd(8'h02, 2, 1, 0, "R4 bad crc");
    run_cmd(8'h37, 1, 0, 0, "R4 unknown op");
    cmd_n = 1; cmdb[0] = 8'd3;
    flag(2'd1); push_bytes(); busy_window();
    chk("R4 short count busy", busy_n, TP);
    xmit(); exp_status(8'hFF); cmp("R4 short count");
    cmd_n = 40; cmdb[0] = 8'd40; cmdb[1] = 8'h01;
    for (int i = 2; i < 40; i++) cmdb[i] = 8'(i);
    flag(2'd1); push_bytes(); busy_window();
    chk("R4 long count busy", busy_n, TP);
    xmit(); exp_status(8'hFF); cmp("R4 long count");

    // R7
    run_cmd(8'h04, 0, 0, 1, "R7 exec fault");
    run_cmd(8'h05, 4, 0, 1, "R7 mac fault");

    // R10: sleep in idle and in receive
    flag(2'd3);
    chk("R10 sleep from idle", mode, 0);
    flag(2'd0); xmit(); exp_status(8'h11); cmp("R10 cleared after idle sleep");
    make_cmd(8'h05, 6, 0);
    flag(2'd1);
    byte_valid = 1'b1; byte_in = cmdb[0]; @(negedge clk);
    byte_in = cmdb[1]; @(negedge clk); byte_valid = 1'b0;
    flag(2'd3);
    chk("R10 sleep from receive", mode, 0);
    flag(2'd0); xmit(); exp_status(8'h11); cmp("R10 cleared after rx sleep");

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [7:0] op = ops[$urandom % 7];
      run_cmd(op, int'($urandom % 29), ($urandom % 5) == 0, ($urandom % 4) == 0, "R6 random");
      if (($urandom % 3) == 0) begin xmit(); cmp("R9 random repeat"); end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule